// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block handles hardware handshaking for a serial port. On the receive side it watches how full the receive FIFO is and drives the RTS pin. RTS drops when the level climbs to a programmable halt mark, and it comes back only when the level has drained to a lower programmable restore mark. The gap between the two marks gives hysteresis, so RTS does not chatter while the level hovers near one threshold.

On the transmit side it resynchronises the incoming CTS pin and produces a transmit-permit level. The transmitter samples this level only at character boundaries. A character already on the wire is therefore always completed, and no new one starts while the far end holds CTS inactive.

The two thresholds come from one 8-bit control word. Each is stored as a 4-bit count of 4-byte units, so the usual setting of halt at 52 and restore at 16 is encoded as 13 and 4. Automatic RTS and automatic CTS have separate enables. Automatic RTS also depends on a software RTS request, which can force RTS inactive at any time.

Top module: `hwfc_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rts_out_n` is 1 (inactive) and the hysteresis state is "not halted". The CTS synchroniser holds "inactive", so with `auto_cts_en`=1 `tx_permit` is 0 until the pin has been sampled low.
- R2: The halt level is `thresh_cfg[3:0]`×4 and the restore level is `thresh_cfg[7:4]`×4, both in bytes and compared against `rx_level`.
- R3: With `auto_rts_en`=1 and `sw_rts_req`=1, a `rx_level` greater than or equal to the halt level makes `rts_out_n` 1 at the next clock edge.
- R4: Once halted, RTS stays inactive while `rx_level` is above the restore level. It becomes active (0) at the edge after `rx_level` is less than or equal to the restore level.
- R5: When `sw_rts_req`=0, `rts_out_n` is 1 from the next edge on, regardless of level or enables.
- R6: When `auto_rts_en`=0, `rts_out_n` is the inverse of `sw_rts_req` one edge later, `rx_level` has no effect, and the hysteresis state returns to "not halted".
- R7: `cts_in_n` passes through a two-flop synchroniser. A pin change at the input reaches `tx_permit` after the second rising edge.
- R8: When `auto_cts_en`=0, `tx_permit` is 1 whatever the CTS pin does.
- R9: When `auto_cts_en`=1, `tx_permit` is 1 exactly when the synchronised CTS is active (pin low).
- R10: If `rx_level` is at or above the halt level and at or below the restore level at the same time, the halt comparison wins and RTS goes inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W (7) | Current receive FIFO fill level in bytes |
| thresh_cfg | input | 2*FIELD_W (8) | [3:0] halt level / 4, [7:4] restore level / 4 |
| sw_rts_req | input | 1 | Software RTS request; 0 forces RTS inactive |
| auto_rts_en | input | 1 | Enable automatic RTS from the FIFO level |
| auto_cts_en | input | 1 | Enable gating of the transmitter by CTS |
| cts_in_n | input | 1 | CTS pin, active low, asynchronous |
| rts_out_n | output | 1 | RTS pin, active low, registered |
| tx_permit | output | 1 | 1 when the transmitter may start a new character |

## Verification
The embedded assertions check on every cycle that a level at the halt mark produces inactive RTS, that a halt-and-restore overlap resolves to halt, that a low software request always wins, that the halted state holds while the level sits between the marks, and that the synchroniser output changes only after its first stage has. The hysteresis path can only be shown by the bench: rising to the halt mark, falling through the band, and reasserting at exactly the restore mark. The same is true of the two-cycle CTS latency against a pin pattern, of changes to the threshold fields, and of the clearing of the halted state when automatic RTS is switched off and back on.

// File: rtl/hwfc_pkg.sv
package hwfc_pkg;
  // Scale a stored threshold field (units of 2**sh bytes) to a byte level.
  function automatic logic [15:0] field_to_level(input logic [7:0] field, input int sh);
    return 16'(field) << sh;
  endfunction
endpackage

// File: rtl/hwfc_cts_sync.sv
module hwfc_cts_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];

  // R7: the output can only fall after the stage before it held 0
  a_r7_sync_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_sync) |-> !$past(chain[STAGES-2]));
endmodule

// File: rtl/hwfc_rts_hyst.sv
module hwfc_rts_hyst #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] restore_lvl,
  input  logic             auto_en,
  input  logic             sw_req,
  output logic             halted,
  output logic             rts_n
);
  logic hit_halt, hit_restore, halted_nxt, rts_n_nxt;

  assign hit_halt    = (level >= halt_lvl);
  assign hit_restore = (level <= restore_lvl);

  always_comb begin
    halted_nxt = halted;
    if (!auto_en)         halted_nxt = 1'b0;
    else if (hit_halt)    halted_nxt = 1'b1;
    else if (hit_restore) halted_nxt = 1'b0;
    rts_n_nxt = !(sw_req && !(auto_en && halted_nxt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0;
      rts_n  <= 1'b1;
    end else begin
      halted <= halted_nxt;
      rts_n  <= rts_n_nxt;
    end
  end

  a_r3_halt_drops_rts: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && hit_halt) |=> rts_n);
  a_r5_sw_low_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_req |=> rts_n);
  a_r4_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && halted && !hit_restore) |=> halted);
  a_r10_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && hit_halt && hit_restore) |=> (halted && rts_n));
  a_r6_manual_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !halted);
endmodule

// File: rtl/hwfc_cts_gate.sv
module hwfc_cts_gate (
  input  logic auto_en,
  input  logic cts_sync_n,
  output logic permit
);
  // R8/R9: with gating off the transmitter is always free to start
  assign permit = !auto_en || !cts_sync_n;
endmodule

// File: rtl/hwfc_top.sv
module hwfc_top #(
  parameter int LVL_W    = 7,
  parameter int FIELD_W  = 4,
  parameter int SCALE_SH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LVL_W-1:0]     rx_level,
  input  logic [2*FIELD_W-1:0] thresh_cfg,
  input  logic                 sw_rts_req,
  input  logic                 auto_rts_en,
  input  logic                 auto_cts_en,
  input  logic                 cts_in_n,
  output logic                 rts_out_n,
  output logic                 tx_permit
);
  import hwfc_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [LVL_W-1:0] halt_lvl, restore_lvl;
  logic             halted_st, cts_sync_n;

  // R2: fields scaled to byte levels
  assign halt_lvl    = LVL_W'(field_to_level(8'(thresh_cfg[FIELD_W-1:0]), SCALE_SH));
  assign restore_lvl = LVL_W'(field_to_level(8'(thresh_cfg[2*FIELD_W-1:FIELD_W]), SCALE_SH));

  hwfc_rts_hyst #(.LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .level(rx_level),
    .halt_lvl(halt_lvl), .restore_lvl(restore_lvl),
    .auto_en(auto_rts_en), .sw_req(sw_rts_req),
    .halted(halted_st), .rts_n(rts_out_n)
  );

  hwfc_cts_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(cts_in_n), .q_sync(cts_sync_n)
  );

  hwfc_cts_gate u_gate (
    .auto_en(auto_cts_en), .cts_sync_n(cts_sync_n), .permit(tx_permit)
  );

  // R1: a halted state only arises from automatic RTS being on
  a_r1_halt_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_st) |-> $past(auto_rts_en));
endmodule

// File: tb/test_hwfc_top.sv
module test_hwfc_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] rx_level = 0;
  logic [7:0] thresh_cfg = 8'h4D;
  logic       sw_rts_req = 0, auto_rts_en = 0, auto_cts_en = 0, cts_in_n = 1;
  logic       rts_out_n, tx_permit;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // staged stimulus
  logic [6:0] s_lvl = 0;
  logic [7:0] s_cfg = 8'h4D;
  logic s_sw = 0, s_ar = 0, s_ac = 0, s_cts = 1;

  // bench model state
  bit m_halted = 0, m_c1 = 1, m_c2 = 1;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  hwfc_top i_hwfc_top (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thresh_cfg(thresh_cfg),
    .sw_rts_req(sw_rts_req), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .cts_in_n(cts_in_n), .rts_out_n(rts_out_n), .tx_permit(tx_permit)
  );

  task automatic drive(input string tag);
    int hl, rl;
    bit er, ep;
    @(negedge clk);
    rx_level = s_lvl; thresh_cfg = s_cfg; sw_rts_req = s_sw;
    auto_rts_en = s_ar; auto_cts_en = s_ac; cts_in_n = s_cts;
    hl = int'(s_cfg[3:0]) * 4;
    rl = int'(s_cfg[7:4]) * 4;
    if (!s_ar) m_halted = 0;
    else if (int'(s_lvl) >= hl) m_halted = 1;
    else if (int'(s_lvl) <= rl) m_halted = 0;
    er = !(s_sw && !(s_ar && m_halted));
    m_c2 = m_c1; m_c1 = s_cts;
    ep = !s_ac || !m_c2;
    exp_q.push_back({er, ep});
    tag_q.push_back(tag);
  endtask

  // monitor: compares shortly after each edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if ({rts_out_n, tx_permit} !== e) begin
          n_bad++;
          $display("FAIL %s: rts_n/permit got %b%b expected %b%b", t, rts_out_n, tx_permit, e[1], e[0]);
        end
      end
    end
  end

  task automatic direct(input string tag, input logic [1:0] got, input logic [1:0] e);
    n_vec++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, e);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    auto_cts_en = 1; s_ac = 1;
    #20;
    direct("R1 reset", {rts_out_n, tx_permit}, 2'b10);
    @(negedge clk); rst_n = 1;

    // R1: first cycle after reset still inactive
    s_sw = 1; s_ar = 1; s_ac = 1; s_cts = 0; s_lvl = 0;
    drive("R1 after reset");
    drive("R7 sync stage 2");
    drive("R9 cts active");
    // R2/R3: halt=52, restore=16 (cfg 0x4D)
    s_lvl = 51; drive("R2 below halt");
    s_lvl = 52; drive("R3 at halt");
    s_lvl = 60; drive("R3 above halt");
    // R4: band holds, restore reasserts
    s_lvl = 40; drive("R4 in band");
    s_lvl = 17; drive("R4 just above restore");
    s_lvl = 16; drive("R4 at restore");
    s_lvl = 30; drive("R4 rising in band");
    // R5
    s_sw = 0; s_lvl = 0; drive("R5 sw low");
    drive("R5 sw low hold");
    s_sw = 1; drive("R5 sw back");
    // R7/R9: cts pattern, two-edge latency
    s_cts = 1; drive("R7 cts high edge1");
    drive("R7 cts high edge2");
    s_cts = 0; drive("R9 cts low edge1");
    s_cts = 1; drive("R7 pulse");
    drive("R7 pulse2");
    drive("R9 cts inactive");
    // R8: gating off
    s_ac = 0; drive("R8 gate off");
    s_cts = 0; drive("R8 gate off cts low");
    s_cts = 1; drive("R8 gate off cts high");
    drive("R8 gate off steady");
    // R6: manual mode ignores level and clears state
    s_lvl = 60; drive("R6 halt before manual");
    s_ar = 0; drive("R6 manual high level");
    s_sw = 0; drive("R6 manual sw low");
    s_sw = 1; drive("R6 manual sw high");
    s_ar = 1; s_lvl = 30; drive("R6 state cleared");
    // R2: other fields, halt=4, restore=0
    s_cfg = 8'h01; s_lvl = 3; drive("R2 small halt below");
    s_lvl = 4; drive("R2 small halt at");
    s_lvl = 1; drive("R2 small in band");
    s_lvl = 0; drive("R2 small restore");
    // R10: halt=8, restore=20 overlap
    s_cfg = 8'h52; s_lvl = 7; drive("R10 below both");
    s_lvl = 10; drive("R10 overlap halts");
    s_lvl = 5; drive("R10 leaves");
    s_lvl = 0; drive("R10 idle");
    @(posedge clk); #3;
    @(posedge clk); #3;
    finish_run();
  end
endmodule